// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a register-mapped general-purpose I/O controller split into a parameterised number of banks. Each bank serves up to 32 pins and has its own width parameter. Every pin can be an input or an output, and an output can run push-pull or open-drain. Each pin can also raise an interrupt. The trigger is chosen per pin from five kinds: rising edge, falling edge, either edge, high level and low level. Every captured event latches a sticky status bit, and software clears that bit by writing a one to it. A per-pin enable decides which latched bits reach the single interrupt line shared by all banks.

Software reaches the registers through a plain word-addressed port. A write takes effect at the clock edge where `reg_we` is high. Read data is a combinational function of `reg_word` and the current register state. Pin inputs pass through a synchroniser before any use, so they may be asynchronous to `clk`.

Top module: `banked_gpio_irq`

## Requirements
- R1: Each bank owns eight consecutive words, and bank n starts at word n*8 (byte n*32). The word index inside a bank selects the register: 0 open-drain select, 1 data, 2 direction, 3 polarity, 4 any-edge select, 5 interrupt enable, 6 level select, 7 status. Bit k of every register belongs to pin k of that bank.
- R2: After reset every register reads 0 and `irq` is 0. Every pin inside a bank's width then has its output enable set, because all pins start as outputs.
- R3: A direction bit of 1 makes the pin an input and 0 makes it an output. `pin_out` carries the data register. Reading the data word returns the synchronised pin for input pins and the data register for output pins.
- R4: With level select 0 and any-edge select 0, polarity 1 latches status on a rising edge and polarity 0 on a falling edge. Status is visible after the third rising clock edge that follows the pin change: two synchroniser stages plus the status register.
- R5: With level select 0 and any-edge select 1, both edges latch status, whatever the polarity bit holds.
- R6: With level select 1, polarity 1 makes the pin active when high and polarity 0 active when low. Status is set again on every cycle while the pin stays active, and a hardware set wins over a clear in the same cycle.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged, and no write can set a status bit.
- R8: `irq` is the OR, over all banks, of status AND enable. A bit whose enable is 0 still latches its status.
- R9: Register bits at or above a bank's width read as 0, never latch status, and keep their output enable at 0.
- R10: For an output pin with open-drain select 1, the output enable is on only while its data bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_word | input | ADDR_W | Word address: bank number above, register index in the low 3 bits |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| pin_in | input | NUM_BANKS*32 | Pad input values, bank b in bits b*32 upward |
| pin_out | output | NUM_BANKS*32 | Output values toward the pads |
| pin_oe | output | NUM_BANKS*32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
Suppose a synchroniser or previous-value flop holds a wrong value. The fault then shows up as a status bit that is wrong in the status read taken three clocks after a pin change. If the fault sits in a pin whose enable is set, `irq` is wrong in that same cycle. A clear that does not take effect, or a status bit that clears itself, shows up in the very next read of the status word. A trigger-mode decode error shows up within the sweep step that applies the matching transition. That sweep covers every transition of five pins, one pin per mode.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int REG_BITS      = 32;
   localparam int WORDS_PER_BNK = 8;
   localparam int IDX_W         = 3;

   typedef enum logic [IDX_W-1:0] {
      RI_DRAIN = 3'd0,
      RI_DATA  = 3'd1,
      RI_DIR   = 3'd2,
      RI_POL   = 3'd3,
      RI_ANY   = 3'd4,
      RI_EN    = 3'd5,
      RI_LEVEL = 3'd6,
      RI_FLAG  = 3'd7
   } reg_idx_e;

   function automatic logic [REG_BITS-1:0] low_ones(input int w);
      logic [REG_BITS-1:0] m;
      m = '0;
      for (int i = 0; i < REG_BITS; i++) begin
         if (i < w) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] now_i,
   input  logic [W-1:0] level_i,
   input  logic [W-1:0] pol_i,
   input  logic [W-1:0] any_i,
   output logic [W-1:0] hit_o
);

   logic [W-1:0] prev_q;
   logic [W-1:0] rise, fall, edge_hit, lvl_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= now_i;
   end

   assign rise = now_i & ~prev_q;
   assign fall = ~now_i & prev_q;

   for (genvar i = 0; i < W; i++) begin : g_pin
      always_comb begin
         if (any_i[i]) edge_hit[i] = rise[i] | fall[i];
         else if (pol_i[i]) edge_hit[i] = rise[i];
         else edge_hit[i] = fall[i];
         lvl_hit[i] = pol_i[i] ? now_i[i] : ~now_i[i];
      end
   end

   assign hit_o = (level_i & lvl_hit) | (~level_i & edge_hit);

endmodule

// File: rtl/gpio_bank_core.sv
module gpio_bank_core
   import gpio_bank_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [REG_BITS-1:0] wr_data,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [REG_BITS-1:0] rd_data,
   input  logic [REG_BITS-1:0] pin_i,
   output logic [REG_BITS-1:0] pin_o,
   output logic [REG_BITS-1:0] pin_oe_o,
   output logic                pend_o
);

   localparam logic [REG_BITS-1:0] VALID = low_ones(WIDTH);

   if (WIDTH < 1 || WIDTH > REG_BITS) begin : g_bad_width
      $error("gpio_bank_core: WIDTH out of 1..32");
   end

   logic [REG_BITS-1:0] drain_q, data_q, dir_q, pol_q, any_q, en_q, lvl_q;
   logic [REG_BITS-1:0] stat_q, stat_d, clr_vec, hit, sync_v;
   logic [REG_BITS-1:0] wval;

   assign wval = wr_data & VALID;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drain_q <= '0; data_q <= '0; dir_q <= '0; pol_q <= '0;
         any_q   <= '0; en_q   <= '0; lvl_q <= '0;
      end else if (wr_en) begin
         case (wr_idx)
            RI_DRAIN: drain_q <= wval;
            RI_DATA:  data_q  <= wval;
            RI_DIR:   dir_q   <= wval;
            RI_POL:   pol_q   <= wval;
            RI_ANY:   any_q   <= wval;
            RI_EN:    en_q    <= wval;
            RI_LEVEL: lvl_q   <= wval;
            default:  ;
         endcase
      end
   end

   gpio_sync #(.W(REG_BITS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_i & VALID), .q_o(sync_v)
   );

   gpio_trig_detect #(.W(REG_BITS)) u_det (
      .clk(clk), .rst_n(rst_n), .now_i(sync_v), .level_i(lvl_q),
      .pol_i(pol_q), .any_i(any_q), .hit_o(hit)
   );

   assign clr_vec = (wr_en && wr_idx == RI_FLAG) ? wr_data : '0;
   assign stat_d  = ((stat_q & ~clr_vec) | hit) & VALID;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   always_comb begin
      case (rd_idx)
         RI_DRAIN: rd_data = drain_q;
         RI_DATA:  rd_data = (dir_q & sync_v) | (~dir_q & data_q);
         RI_DIR:   rd_data = dir_q;
         RI_POL:   rd_data = pol_q;
         RI_ANY:   rd_data = any_q;
         RI_EN:    rd_data = en_q;
         RI_LEVEL: rd_data = lvl_q;
         default:  rd_data = stat_q;
      endcase
   end

   assign pin_o    = data_q;
   assign pin_oe_o = VALID & ~dir_q & ~(drain_q & data_q);
   assign pend_o   = |(stat_q & en_q);

   // R7: a latched bit survives every cycle that carries no clear for it
   p_stat_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(stat_q) & ~$past(clr_vec)) & ~stat_q) == '0));

   // R4: a newly latched edge-mode bit needs a change of the synchronised pin
   p_edge_needs_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & ~$past(stat_q) & ~$past(lvl_q) &
        ~($past(sync_v) ^ $past(sync_v, 2))) == '0));

   // R6: an active level keeps its status bit set, even against a clear
   p_level_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(lvl_q) & ~($past(pol_q) ^ $past(sync_v))) & VALID & ~stat_q) == '0));

   // R9: no output enable above the bank width
   p_oe_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe_o & ~VALID) == '0));

   // R10: open-drain pins never drive a high value
   p_open_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe_o & drain_q & pin_o) == '0));

endmodule

// File: rtl/banked_gpio_irq.sv
module banked_gpio_irq
   import gpio_bank_pkg::*;
#(
   parameter int                     NUM_BANKS   = 2,
   parameter logic [NUM_BANKS*8-1:0] BANK_WIDTHS = {8'd5, 8'd32},
   parameter int                     SYNC_STAGES = 2,
   localparam int BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int ADDR_W     = BANK_SEL_W + IDX_W,
   localparam int PINS       = NUM_BANKS * REG_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_word,
   input  logic [REG_BITS-1:0] reg_wdata,
   output logic [REG_BITS-1:0] reg_rdata,
   input  logic [PINS-1:0]     pin_in,
   output logic [PINS-1:0]     pin_out,
   output logic [PINS-1:0]     pin_oe,
   output logic                irq
);

   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("banked_gpio_irq: NUM_BANKS must be at least 1");
   end

   logic [BANK_SEL_W-1:0] bank_field;
   logic [IDX_W-1:0]      idx_field;
   logic [REG_BITS-1:0]   bank_rd [NUM_BANKS];
   logic [NUM_BANKS-1:0]  bank_hit;
   logic [NUM_BANKS-1:0]  bank_pend;

   assign bank_field = reg_word[ADDR_W-1:IDX_W];
   assign idx_field  = reg_word[IDX_W-1:0];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int BW = int'(BANK_WIDTHS[b*8 +: 8]);

      assign bank_hit[b] = (bank_field == BANK_SEL_W'(b));

      gpio_bank_core #(.WIDTH(BW), .SYNC_STAGES(SYNC_STAGES)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_we & bank_hit[b]),
         .wr_idx  (idx_field),
         .wr_data (reg_wdata),
         .rd_idx  (idx_field),
         .rd_data (bank_rd[b]),
         .pin_i   (pin_in[b*REG_BITS +: REG_BITS]),
         .pin_o   (pin_out[b*REG_BITS +: REG_BITS]),
         .pin_oe_o(pin_oe[b*REG_BITS +: REG_BITS]),
         .pend_o  (bank_pend[b])
      );
   end

   always_comb begin
      reg_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bank_hit[b]) reg_rdata = reg_rdata | bank_rd[b];
      end
   end

   assign irq = |bank_pend;

endmodule

// File: tb/sim_banked_gpio_irq.sv
`timescale 1ns/1ps
module sim_banked_gpio_irq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_word = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] pin_in = '0;
   logic [63:0] pin_out, pin_oe;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   banked_gpio_irq u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_word(reg_word),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int b, input int i, input logic [31:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_word = 4'(b*8 + i); reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int b, input int i, output logic [31:0] v);
      @(negedge clk);
      reg_word = 4'(b*8 + i);
      #1 v = reg_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      logic [31:0] pat;
      logic [4:0]  oldp, newp;
      logic [4:0]  e;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R2: reset state
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < 8; i++) begin
            rd(b, i, v);
            chk("R2 reset read", 64'(v), 64'h0);
         end
      #1;
      chk("R2 reset oe / R9 width", pin_oe, {27'h0, 5'h1f, 32'hffffffff});
      chk("R2 reset irq", 64'(irq), 64'h0);

      // R1, R9: per-register placement and width masking
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < 7; i++) begin
            pat = 32'h5A00_0000 ^ (32'hFFFF_FFFF >> i) ^ 32'(b << 8);
            wr(b, i, pat);
            for (int j = 0; j < 7; j++) begin
               rd(b, j, v);
               chk("R1 register map", 64'(v),
                   (j == i) ? 64'(pat & ((b == 0) ? 32'hFFFF_FFFF : 32'h1F)) : 64'h0);
            end
            wr(b, i, 32'h0);
         end
      wr(0, 7, 32'hFFFF_FFFF);
      rd(0, 7, v);
      chk("R7 write cannot set status", 64'(v), 64'h0);

      // R3: direction and data readback
      wr(0, 2, 32'h0000_FFFF);
      wr(0, 1, 32'h1234_5678);
      @(negedge clk) pin_in[31:0] = 32'hCAFE_BABE;
      settle();
      rd(0, 1, v);
      chk("R3 data readback", 64'(v), 64'h1234_BABE);
      chk("R3 pin_out", 64'(pin_out[31:0]), 64'h1234_5678);
      chk("R3 output enable", 64'(pin_oe[31:0]), 64'hFFFF_0000);

      // R10: open drain
      wr(0, 0, 32'hFFFF_0000);
      #1;
      chk("R10 open drain oe", 64'(pin_oe[31:0]), 64'hEDCB_0000);

      wr(0, 0, 32'h0);
      wr(0, 1, 32'h0);
      wr(0, 2, 32'h0);
      @(negedge clk) pin_in = '0;
      settle();
      wr(0, 7, 32'hFFFF_FFFF);
      wr(1, 7, 32'hFFFF_FFFF);
      rd(0, 7, v);
      chk("R7 clear all", 64'(v), 64'h0);

      // Modes: pin0 rising, pin1 falling, pin2 any edge (polarity set, ignored),
      // pin3 high level, pin4 low level; bank 1 configured with extra high bits
      wr(0, 3, 32'h0000_000D);
      wr(0, 4, 32'h0000_0004);
      wr(0, 6, 32'h0000_0018);
      wr(1, 3, 32'hFFFF_FFED);
      wr(1, 4, 32'hFFFF_FFE4);
      wr(1, 6, 32'hFFFF_FFF8);
      rd(1, 6, v);
      chk("R9 level reg masked", 64'(v), 64'h18);
      rd(1, 3, v);
      chk("R9 polarity reg masked", 64'(v), 64'h0D);

      oldp = 5'h0;
      for (int k = 0; k < 64; k++) begin
         newp = 5'((k * 13 + 5) & 31);
         if (k == 63) newp = 5'h0;
         wr(0, 7, 32'hFFFF_FFFF);
         wr(1, 7, 32'hFFFF_FFFF);
         @(negedge clk);
         pin_in[4:0]   = newp;
         pin_in[36:32] = newp;
         pin_in[63:37] = {27{k[0]}};
         settle();
         e[0] = newp[0] & ~oldp[0];
         e[1] = oldp[1] & ~newp[1];
         e[2] = newp[2] ^ oldp[2];
         e[3] = oldp[3] | newp[3];
         e[4] = ~oldp[4] | ~newp[4];
         rd(0, 7, v);
         chk("R4 R5 R6 mode sweep bank0", 64'(v), 64'(e));
         rd(1, 7, v);
         chk("R9 mode sweep bank1", 64'(v), 64'(e));
         oldp = newp;
      end

      // R6: set wins over clear while level active
      @(negedge clk) pin_in[3] = 1'b1;
      settle();
      wr(0, 7, 32'h8);
      rd(0, 7, v);
      chk("R6 level holds against clear", 64'(v[3]), 64'h1);
      @(negedge clk) pin_in[3] = 1'b0;
      settle();
      wr(0, 7, 32'h8);
      rd(0, 7, v);
      chk("R6 clear after level gone", 64'(v[3]), 64'h0);

      // R8: enable gating and combination
      wr(0, 7, 32'hFFFF_FFFF);
      wr(1, 7, 32'hFFFF_FFFF);
      rd(1, 7, v);
      chk("R8 status latches while disabled", 64'(v), 64'h10);
      chk("R8 irq low when disabled", 64'(irq), 64'h0);
      wr(1, 5, 32'h10);
      #1;
      chk("R8 irq from bank1", 64'(irq), 64'h1);
      wr(1, 5, 32'h0);
      wr(0, 5, 32'h1);
      #1;
      chk("R8 irq off with clear pin", 64'(irq), 64'h0);

      // R4: latency of a rising edge
      @(negedge clk) pin_in[0] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      reg_word = 4'd7;
      #1;
      chk("R4 status not yet set", 64'(reg_rdata[0]), 64'h0);
      chk("R4 irq not yet set", 64'(irq), 64'h0);
      @(negedge clk);
      #1;
      chk("R4 status on third edge", 64'(reg_rdata[0]), 64'h1);
      chk("R8 irq follows enabled status", 64'(irq), 64'h1);

      // R7: zero bits do not clear
      wr(0, 7, 32'hFFFF_FFFE);
      rd(0, 7, v);
      chk("R7 zero write keeps bit", 64'(v[0]), 64'h1);
      wr(0, 7, 32'h1);
      rd(0, 7, v);
      chk("R7 one write clears bit", 64'(v[0]), 64'h0);
      chk("R8 irq after clear", 64'(irq), 64'h0);

      finish_run();
   end

endmodule